// File: doc/BRIEF.md
# Layer Instruction Tile Sequencer

This block drives a convolution accelerator one network layer at a time. For each layer it reads one 80-bit instruction word from an instruction area of memory and keeps the decoded copy in a local register. It then walks the layer's tiles, handing out start commands with tile coordinates to three sub-units: a load unit that brings in weights and input features, a compute engine, and a store unit that writes results back. The tile stream is a three-stage pipeline. In every step the load of tile s, the compute of tile s-1 and the store of the results finished at tile s-2 are issued together, and a step only begins once all three units are idle.

Fully connected layers run on the same engine. The decoder rewrites their parameters so that the weight matrix takes the place of the input feature maps. The host writes a layer count and pulses start. The block fetches and runs that many instructions, drains the pipeline after each layer, and then raises done. A malformed instruction stops the run and raises an error flag.

Top module: `layer_tile_sequencer`

## Requirements
- R1: The type field is bits [1:0] of the instruction word: 0 is a convolution and 1 is a fully connected layer. A type of 2 or 3 is an error. So is a zero in any resulting map count or map size, and so is a zero kernel factor on a fully connected layer. An error sets err, and err holds until the next start. No load, compute, store or fetch is issued while err is set.
- R2: Exactly one instruction read is made per layer, at address INSTR_BASE + layer_idx. It is made only after every unit is idle and the previous layer has fully drained.
- R3: Tiles are visited with the input-channel tile index innermost, then the output-channel tile, then the column tile, then the row tile. The number of tiles along each dimension is ceil(size / tile size). Each position port packs row, col, och and ich tile indices from the high bits down, CW bits each.
- R4: In each pipeline step, any load is for tile s, any compute is for tile s-1, and any store is for the result completed at tile s-2. A layer of T tiles issues T loads and T computes.
- R5: A store is issued only for tiles that end an input-channel group. There is one store per spatial/output-channel group, and st_pos carries the coordinates of that last tile.
- R6: cp_first is high with a compute exactly when its input-channel tile index is 0. cp_last is high exactly when that index is the last one.
- R7: No start is issued while any of the three busy inputs is high. Each unit must raise busy in the cycle after its start.
- R8: A fully connected layer uses these fields: input count in [17:2], output count in [33:18], factor ker in [61:58] and batch in [79:74]. It is presented as a convolution with input maps = inputs / ker, output maps = batch, 1 row, columns = outputs, and kernel = stride = ker. Pad is 0. Its row, column, stride and pad fields are ignored.
- R9: A convolution passes its fields to the cfg ports unchanged. The fields are: input maps [17:2], output maps [33:18], rows [45:34], columns [57:46], kernel [61:58], stride [65:62], pad [69:66], activation flag [70] and pool size [73:71].
- R10: The run ends after num_layers layers (sampled at start), and done rises only after the last store of the final layer has completed. A count of 0 sets done without any fetch. done and err are never high together.
- R11: After reset done, err, imem_rd and all starts are low, and layer_idx is 0.
- R12: layer_idx counts finished layers. It steps by one as each layer drains and returns to 0 on start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle, done or in error) |
| num_layers | input | LW | Number of layers to run |
| imem_rd | output | 1 | Instruction read strobe |
| imem_addr | output | AW | Instruction address |
| imem_data | input | 80 | Instruction word, valid the cycle after imem_rd |
| ld_start | output | 1 | Load command |
| ld_pos | output | 4*CW | Load tile position |
| ld_busy | input | 1 | Load unit busy |
| cp_start | output | 1 | Compute command |
| cp_pos | output | 4*CW | Compute tile position |
| cp_first | output | 1 | First input-channel tile of a group |
| cp_last | output | 1 | Last input-channel tile of a group |
| cp_busy | input | 1 | Compute engine busy |
| st_start | output | 1 | Store command |
| st_pos | output | 4*CW | Store tile position |
| st_busy | input | 1 | Store unit busy |
| cfg_in_ch | output | 16 | Effective input map count |
| cfg_out_ch | output | 16 | Effective output map count |
| cfg_rows | output | 16 | Effective rows |
| cfg_cols | output | 16 | Effective columns |
| cfg_kernel | output | 4 | Kernel size |
| cfg_stride | output | 4 | Stride |
| cfg_pad | output | 4 | Padding |
| cfg_relu | output | 1 | Activation enable |
| cfg_pool | output | 3 | Pool size |
| layer_idx | output | LW | Finished-layer count |
| done | output | 1 | Run complete |
| err | output | 1 | Bad instruction seen |

## Verification
The load of the next tile and the store of an earlier tile's result can both be issued in the same cycle, together with the compute of the tile between them. This is provoked by runs where the three unit models use equal one-cycle latencies, and by runs with random latencies. The bench checks every such cycle by tile index. The load must be exactly two tiles ahead of the stored tile, and the compute must be exactly one tile ahead of it. Tiles that do not end an input-channel group must never reach the store unit.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int IW = 80;

  // instruction word field positions
  localparam int F_TYPE = 0;
  localparam int F_NIN = 2;
  localparam int F_NOUT = 18;
  localparam int F_ROWS = 34;
  localparam int F_COLS = 46;
  localparam int F_KER = 58;
  localparam int F_STR = 62;
  localparam int F_PAD = 66;
  localparam int F_RELU = 70;
  localparam int F_POOL = 71;
  localparam int F_BAT = 74;

  localparam logic [1:0] OP_CONV = 2'd0;
  localparam logic [1:0] OP_FCN = 2'd1;

  typedef struct packed {
    logic [15:0] in_ch;
    logic [15:0] out_ch;
    logic [15:0] rows;
    logic [15:0] cols;
    logic [3:0]  kernel;
    logic [3:0]  stride;
    logic [3:0]  pad;
    logic        relu;
    logic [2:0]  pool;
  } layer_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_RUN, S_DONE, S_ERR
  } seq_state_e;
endpackage

// File: rtl/seq_instr_decode.sv
module seq_instr_decode
  import seq_pkg::*;
(
  input  logic [IW-1:0] word,
  output layer_cfg_t    cfg,
  output logic          bad
);
  logic [1:0]  op;
  logic [15:0] nin, nout;
  logic [3:0]  ker, divisor;
  logic [5:0]  batch;

  always_comb begin
    op      = word[F_TYPE +: 2];
    nin     = word[F_NIN +: 16];
    nout    = word[F_NOUT +: 16];
    ker     = word[F_KER +: 4];
    batch   = word[F_BAT +: 6];
    divisor = (ker == 4'd0) ? 4'd1 : ker;

    cfg.relu = word[F_RELU];
    cfg.pool = word[F_POOL +: 3];
    if (op == OP_FCN) begin
      // weight-major remap: the weight matrix becomes the input maps
      cfg.in_ch  = nin / {12'd0, divisor};
      cfg.out_ch = {10'd0, batch};
      cfg.rows   = 16'd1;
      cfg.cols   = nout;
      cfg.kernel = ker;
      cfg.stride = ker;
      cfg.pad    = 4'd0;
    end else begin
      cfg.in_ch  = nin;
      cfg.out_ch = nout;
      cfg.rows   = {4'd0, word[F_ROWS +: 12]};
      cfg.cols   = {4'd0, word[F_COLS +: 12]};
      cfg.kernel = ker;
      cfg.stride = word[F_STR +: 4];
      cfg.pad    = word[F_PAD +: 4];
    end

    bad = ((op != OP_CONV) && (op != OP_FCN)) ||
          (cfg.in_ch == 16'd0) || (cfg.out_ch == 16'd0) ||
          (cfg.rows == 16'd0) || (cfg.cols == 16'd0) ||
          ((op == OP_FCN) && (ker == 4'd0));
  end
endmodule

// File: rtl/seq_tile_walker.sv
module seq_tile_walker
  import seq_pkg::*;
#(
  parameter int CW = 16,
  parameter int TR = 4,
  parameter int TC = 8,
  parameter int TM = 4,
  parameter int TN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  layer_cfg_t      cfg,
  output logic [4*CW-1:0] pos,
  output logic            first_n,
  output logic            last_n,
  output logic            last_tile
);
  localparam int NDIM = 4;   // 0: in-channel, 1: out-channel, 2: column, 3: row

  logic [15:0]   dims   [NDIM];
  logic [CW-1:0] cnt_q  [NDIM];
  logic [CW-1:0] lim    [NDIM];
  logic [NDIM-1:0] at_max;
  logic [NDIM:0]   carry;

  always_comb begin
    dims[0] = cfg.in_ch;
    dims[1] = cfg.out_ch;
    dims[2] = cfg.cols;
    dims[3] = cfg.rows;
  end

  assign carry[0] = adv;

  for (genvar k = 0; k < NDIM; k++) begin : g_dim
    localparam int TSZ = (k == 0) ? TN : (k == 1) ? TM : (k == 2) ? TC : TR;
    logic [16:0] sum;
    logic [CW-1:0] cnt_d;
    logic cnt_en;

    assign sum      = {1'b0, dims[k]} + 17'(TSZ - 1);
    assign lim[k]   = CW'(sum / 17'(TSZ));
    assign at_max[k] = (cnt_q[k] == lim[k] - CW'(1));
    assign carry[k+1] = carry[k] & at_max[k];

    always_comb begin
      cnt_en = clr | carry[k];
      if (clr || at_max[k]) cnt_d = '0;
      else                  cnt_d = cnt_q[k] + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[k] <= '0;
      else if (cnt_en) cnt_q[k] <= cnt_d;
    end
  end

  assign pos       = {cnt_q[3], cnt_q[2], cnt_q[1], cnt_q[0]};
  assign first_n   = (cnt_q[0] == '0);
  assign last_n    = at_max[0];
  assign last_tile = &at_max;
endmodule

// File: rtl/layer_tile_sequencer.sv
module layer_tile_sequencer
  import seq_pkg::*;
#(
  parameter int          AW = 12,
  parameter int          LW = 8,
  parameter int          CW = 16,
  parameter int          TR = 4,
  parameter int          TC = 8,
  parameter int          TM = 4,
  parameter int          TN = 4,
  parameter int unsigned INSTR_BASE = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LW-1:0]       num_layers,
  output logic                imem_rd,
  output logic [AW-1:0]       imem_addr,
  input  logic [79:0]         imem_data,
  output logic                ld_start,
  output logic [4*CW-1:0]     ld_pos,
  input  logic                ld_busy,
  output logic                cp_start,
  output logic [4*CW-1:0]     cp_pos,
  output logic                cp_first,
  output logic                cp_last,
  input  logic                cp_busy,
  output logic                st_start,
  output logic [4*CW-1:0]     st_pos,
  input  logic                st_busy,
  output logic [15:0]         cfg_in_ch,
  output logic [15:0]         cfg_out_ch,
  output logic [15:0]         cfg_rows,
  output logic [15:0]         cfg_cols,
  output logic [3:0]          cfg_kernel,
  output logic [3:0]          cfg_stride,
  output logic [3:0]          cfg_pad,
  output logic                cfg_relu,
  output logic [2:0]          cfg_pool,
  output logic [LW-1:0]       layer_idx,
  output logic                done,
  output logic                err
);
  localparam int POS_W = 4 * CW;

  seq_state_e state_q, state_d;
  logic [LW-1:0]    layer_q, layer_d, nl_q, nl_d;
  layer_cfg_t       cfg_q, dec_cfg;
  logic             dec_bad, cfg_en;
  logic             ld_done_q, ld_done_d;
  logic             cp_v_q, cp_v_d, cp_fst_q, cp_fst_d, cp_lst_q, cp_lst_d;
  logic [POS_W-1:0] cp_pos_q, cp_pos_d, st_pos_q, st_pos_d;
  logic             st_v_q, st_v_d;
  logic             walk_clr, any_busy, pending, fire;
  logic [POS_W-1:0] w_pos;
  logic             w_first, w_last, w_last_tile;

  seq_instr_decode u_dec (
    .word (imem_data),
    .cfg  (dec_cfg),
    .bad  (dec_bad)
  );

  seq_tile_walker #(.CW(CW), .TR(TR), .TC(TC), .TM(TM), .TN(TN)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (walk_clr),
    .adv       (ld_start),
    .cfg       (cfg_q),
    .pos       (w_pos),
    .first_n   (w_first),
    .last_n    (w_last),
    .last_tile (w_last_tile)
  );

  assign any_busy = ld_busy | cp_busy | st_busy;
  assign pending  = !ld_done_q | cp_v_q | st_v_q;
  assign fire     = (state_q == S_RUN) && !any_busy && pending;

  always_comb begin
    state_d   = state_q;
    layer_d   = layer_q;
    nl_d      = nl_q;
    cfg_en    = 1'b0;
    walk_clr  = 1'b0;
    ld_done_d = ld_done_q;
    cp_v_d    = cp_v_q;
    cp_pos_d  = cp_pos_q;
    cp_fst_d  = cp_fst_q;
    cp_lst_d  = cp_lst_q;
    st_v_d    = st_v_q;
    st_pos_d  = st_pos_q;
    case (state_q)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          layer_d = '0;
          nl_d    = num_layers;
          state_d = (num_layers == '0) ? S_DONE : S_FETCH;
        end
      end
      S_FETCH: state_d = S_DECODE;
      S_DECODE: begin
        cfg_en    = 1'b1;
        walk_clr  = 1'b1;
        ld_done_d = 1'b0;
        cp_v_d    = 1'b0;
        st_v_d    = 1'b0;
        state_d   = dec_bad ? S_ERR : S_RUN;
      end
      S_RUN: begin
        if (fire) begin
          // shift the three-stage tile pipeline
          st_v_d    = cp_v_q & cp_lst_q;
          st_pos_d  = cp_pos_q;
          cp_v_d    = !ld_done_q;
          cp_pos_d  = w_pos;
          cp_fst_d  = w_first;
          cp_lst_d  = w_last;
          ld_done_d = ld_done_q | w_last_tile;
        end else if (!any_busy) begin
          layer_d = layer_q + LW'(1);
          state_d = (layer_q + LW'(1) == nl_q) ? S_DONE : S_FETCH;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      layer_q   <= '0;
      nl_q      <= '0;
      ld_done_q <= 1'b1;
      cp_v_q    <= 1'b0;
      cp_pos_q  <= '0;
      cp_fst_q  <= 1'b0;
      cp_lst_q  <= 1'b0;
      st_v_q    <= 1'b0;
      st_pos_q  <= '0;
    end else begin
      state_q   <= state_d;
      layer_q   <= layer_d;
      nl_q      <= nl_d;
      ld_done_q <= ld_done_d;
      cp_v_q    <= cp_v_d;
      cp_pos_q  <= cp_pos_d;
      cp_fst_q  <= cp_fst_d;
      cp_lst_q  <= cp_lst_d;
      st_v_q    <= st_v_d;
      st_pos_q  <= st_pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= dec_cfg;
  end

  assign imem_rd   = (state_q == S_FETCH);
  assign imem_addr = AW'(INSTR_BASE) + AW'(layer_q);
  assign ld_start  = fire & !ld_done_q;
  assign ld_pos    = w_pos;
  assign cp_start  = fire & cp_v_q;
  assign cp_pos    = cp_pos_q;
  assign cp_first  = cp_fst_q;
  assign cp_last   = cp_lst_q;
  assign st_start  = fire & st_v_q;
  assign st_pos    = st_pos_q;

  assign cfg_in_ch  = cfg_q.in_ch;
  assign cfg_out_ch = cfg_q.out_ch;
  assign cfg_rows   = cfg_q.rows;
  assign cfg_cols   = cfg_q.cols;
  assign cfg_kernel = cfg_q.kernel;
  assign cfg_stride = cfg_q.stride;
  assign cfg_pad    = cfg_q.pad;
  assign cfg_relu   = cfg_q.relu;
  assign cfg_pool   = cfg_q.pool;

  assign layer_idx = layer_q;
  assign done      = (state_q == S_DONE);
  assign err       = (state_q == S_ERR);
endmodule

// File: rtl/layer_tile_sequencer_chk.sv
module layer_tile_sequencer_chk #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          imem_rd,
  input logic          ld_start,
  input logic          cp_start,
  input logic          st_start,
  input logic          ld_busy,
  input logic          cp_busy,
  input logic          st_busy,
  input logic [LW-1:0] layer_idx,
  input logic          done,
  input logic          err
);
  logic any_start, any_busy;
  assign any_start = ld_start | cp_start | st_start;
  assign any_busy  = ld_busy | cp_busy | st_busy;

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    any_start |-> !any_busy); // R7

  AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !(any_start || imem_rd)); // R10

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err); // R1

  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> !imem_rd); // R2

  AST_FETCH_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |-> !any_busy && !any_start); // R2

  AST_LAYER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (layer_idx == $past(layer_idx)) ||
               (layer_idx == $past(layer_idx) + LW'(1))); // R12

  always @(posedge clk) begin
    if (rst_n) begin
      AST_DONE_ERR_EXCL: assert (!(done && err)); // R10
    end
  end
endmodule

bind layer_tile_sequencer layer_tile_sequencer_chk #(.LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .imem_rd   (imem_rd),
  .ld_start  (ld_start),
  .cp_start  (cp_start),
  .st_start  (st_start),
  .ld_busy   (ld_busy),
  .cp_busy   (cp_busy),
  .st_busy   (st_busy),
  .layer_idx (layer_idx),
  .done      (done),
  .err       (err)
);

// File: tb/layer_tile_sequencer_tb.sv
module layer_tile_sequencer_tb;
  localparam int CLK_P = 10;
  localparam int AW = 12, LW = 8, CW = 16;
  localparam int TR = 4, TC = 8, TM = 4, TN = 4;
  localparam int BASE = 64;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [LW-1:0] num_layers;
  logic imem_rd;
  logic [AW-1:0] imem_addr;
  logic [79:0] imem_data;
  logic ld_start, cp_start, st_start, cp_first, cp_last;
  logic ld_busy, cp_busy, st_busy;
  logic [63:0] ld_pos, cp_pos, st_pos;
  logic [15:0] cfg_in_ch, cfg_out_ch, cfg_rows, cfg_cols;
  logic [3:0] cfg_kernel, cfg_stride, cfg_pad;
  logic cfg_relu;
  logic [2:0] cfg_pool;
  logic [LW-1:0] layer_idx;
  logic done, err;

  always #(CLK_P/2) clk = ~clk;

  layer_tile_sequencer #(.AW(AW), .LW(LW), .CW(CW), .TR(TR), .TC(TC), .TM(TM), .TN(TN),
                         .INSTR_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_layers(num_layers),
    .imem_rd(imem_rd), .imem_addr(imem_addr), .imem_data(imem_data),
    .ld_start(ld_start), .ld_pos(ld_pos), .ld_busy(ld_busy),
    .cp_start(cp_start), .cp_pos(cp_pos), .cp_first(cp_first), .cp_last(cp_last),
    .cp_busy(cp_busy), .st_start(st_start), .st_pos(st_pos), .st_busy(st_busy),
    .cfg_in_ch(cfg_in_ch), .cfg_out_ch(cfg_out_ch), .cfg_rows(cfg_rows),
    .cfg_cols(cfg_cols), .cfg_kernel(cfg_kernel), .cfg_stride(cfg_stride),
    .cfg_pad(cfg_pad), .cfg_relu(cfg_relu), .cfg_pool(cfg_pool),
    .layer_idx(layer_idx), .done(done), .err(err)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // layer table
  int typ[16], nin[16], nout[16], rws[16], cls[16], ker[16], strd[16], pd[16], rl[16], pl[16], bat[16];
  int e_in[16], e_out[16], e_rows[16], e_cols[16], e_k[16], e_s[16], e_p[16];
  int tn[16], tm[16], tc[16], tr[16];
  logic [79:0] prog[16];

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic logic [79:0] enc(int i);
    logic [79:0] w = '0;
    w[1:0] = 2'(typ[i]);   w[17:2] = 16'(nin[i]);  w[33:18] = 16'(nout[i]);
    w[45:34] = 12'(rws[i]); w[57:46] = 12'(cls[i]); w[61:58] = 4'(ker[i]);
    w[65:62] = 4'(strd[i]); w[69:66] = 4'(pd[i]);   w[70] = rl[i][0];
    w[73:71] = 3'(pl[i]);   w[79:74] = 6'(bat[i]);
    return w;
  endfunction

  task automatic set_layer(int i, int t, int a, int b, int r, int c, int k, int s, int p, int rel, int pool, int bt);
    typ[i] = t; nin[i] = a; nout[i] = b; rws[i] = r; cls[i] = c; ker[i] = k;
    strd[i] = s; pd[i] = p; rl[i] = rel; pl[i] = pool; bat[i] = bt;
    if (t == 1) begin
      e_in[i] = (k == 0) ? 0 : a / k; e_out[i] = bt; e_rows[i] = 1; e_cols[i] = b;
      e_k[i] = k; e_s[i] = k; e_p[i] = 0;
    end else begin
      e_in[i] = a; e_out[i] = b; e_rows[i] = r; e_cols[i] = c;
      e_k[i] = k; e_s[i] = s; e_p[i] = p;
    end
    tn[i] = cdiv(e_in[i], TN); tm[i] = cdiv(e_out[i], TM);
    tc[i] = cdiv(e_cols[i], TC); tr[i] = cdiv(e_rows[i], TR);
    prog[i] = enc(i);
  endtask

  function automatic logic [63:0] tpos(int li, int L);
    int n, m, c, r, q;
    n = L % tn[li]; q = L / tn[li];
    m = q % tm[li]; q = q / tm[li];
    c = q % tc[li]; r = q / tc[li];
    return {16'(r), 16'(c), 16'(m), 16'(n)};
  endfunction

  // instruction memory: one-cycle read latency
  always @(posedge clk) if (imem_rd) imem_data <= prog[(int'(imem_addr) - BASE) & 15];

  // sub-unit models: busy rises the cycle after start
  int lat_fix = 0;
  int ld_c, cp_c, st_c;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ld_c <= 0; cp_c <= 0; st_c <= 0; end
    else begin
      if (ld_start) ld_c <= (lat_fix != 0) ? lat_fix : 1 + int'($urandom % 4);
      else if (ld_c != 0) ld_c <= ld_c - 1;
      if (cp_start) cp_c <= (lat_fix != 0) ? lat_fix : 1 + int'($urandom % 4);
      else if (cp_c != 0) cp_c <= cp_c - 1;
      if (st_start) st_c <= (lat_fix != 0) ? lat_fix : 1 + int'($urandom % 4);
      else if (st_c != 0) st_c <= st_c - 1;
    end
  end
  assign ld_busy = (ld_c != 0);
  assign cp_busy = (cp_c != 0);
  assign st_busy = (st_c != 0);

  // monitor
  bit mon_en = 0;
  int cnt_ld = 0, cnt_cp = 0, cnt_st = 0, prev_li = 0, fetch_cnt = 0, overlap = 0;

  task automatic endcheck(int li);
    int tot;
    tot = tn[li] * tm[li] * tc[li] * tr[li];
    chk(cnt_ld == tot, "R4 load count", 64'(cnt_ld), 64'(tot));
    chk(cnt_cp == tot, "R4 compute count", 64'(cnt_cp), 64'(tot));
    chk(cnt_st == tot / tn[li], "R5 store count", 64'(cnt_st), 64'(tot / tn[li]));
  endtask

  always @(negedge clk) begin
    int li, lst;
    logic [63:0] e;
    string tg;
    if (rst_n && mon_en) begin
      if (int'(layer_idx) != prev_li) begin
        if (int'(layer_idx) == prev_li + 1) endcheck(prev_li);
        cnt_ld = 0; cnt_cp = 0; cnt_st = 0;
        prev_li = int'(layer_idx);
      end
      li = int'(layer_idx) & 15;
      if ((ld_start || cp_start || st_start) && (ld_busy || cp_busy || st_busy))
        chk(0, "R7 start while busy", 64'(1), 64'(0));
      if ((done || err) && (ld_start || cp_start || st_start || imem_rd))
        chk(0, "R1 R10 activity after end", 64'(1), 64'(0));
      if (imem_rd) begin
        fetch_cnt++;
        chk(int'(imem_addr) == BASE + int'(layer_idx), "R2 fetch address", 64'(imem_addr), 64'(BASE + int'(layer_idx)));
      end
      if (ld_start) begin
        e = tpos(li, cnt_ld);
        chk(ld_pos == e, "R3 load order", ld_pos, e);
        if (cnt_ld == 0) begin
          tg = (typ[li] == 1) ? "R8 fcn remap" : "R9 conv fields";
          chk({cfg_in_ch, cfg_out_ch} == {16'(e_in[li]), 16'(e_out[li])}, tg,
              64'({cfg_in_ch, cfg_out_ch}), 64'({16'(e_in[li]), 16'(e_out[li])}));
          chk({cfg_rows, cfg_cols} == {16'(e_rows[li]), 16'(e_cols[li])}, tg,
              64'({cfg_rows, cfg_cols}), 64'({16'(e_rows[li]), 16'(e_cols[li])}));
          chk({cfg_kernel, cfg_stride, cfg_pad, cfg_relu, cfg_pool} ==
              {4'(e_k[li]), 4'(e_s[li]), 4'(e_p[li]), rl[li][0], 3'(pl[li])}, tg,
              64'({cfg_kernel, cfg_stride, cfg_pad, cfg_relu, cfg_pool}),
              64'({4'(e_k[li]), 4'(e_s[li]), 4'(e_p[li]), rl[li][0], 3'(pl[li])}));
        end
      end
      if (cp_start) begin
        e = tpos(li, cnt_cp);
        chk(cp_pos == e, "R3 compute order", cp_pos, e);
        chk(cp_first == (e[15:0] == 16'd0), "R6 first flag", 64'(cp_first), 64'(e[15:0] == 16'd0));
        chk(cp_last == (int'(e[15:0]) == tn[li] - 1), "R6 last flag", 64'(cp_last), 64'(int'(e[15:0]) == tn[li] - 1));
      end
      if (ld_start && cp_start)
        chk(cnt_ld == cnt_cp + 1, "R4 load leads compute", 64'(cnt_ld), 64'(cnt_cp + 1));
      if (st_start) begin
        lst = cnt_st * tn[li] + tn[li] - 1;
        e = tpos(li, lst);
        chk(st_pos == e, "R5 store tile", st_pos, e);
        if (cp_start) chk(cnt_cp == lst + 1, "R4 compute leads store", 64'(cnt_cp), 64'(lst + 1));
        if (ld_start) begin
          overlap++;
          chk(cnt_ld == lst + 2, "R4 load and store overlap", 64'(cnt_ld), 64'(lst + 2));
        end
      end
      if (ld_start) cnt_ld++;
      if (cp_start) cnt_cp++;
      if (st_start) cnt_st++;
    end
  end

  task automatic go(int nl);
    @(negedge clk);
    prev_li = int'(layer_idx);
    cnt_ld = 0; cnt_cp = 0; cnt_st = 0; fetch_cnt = 0; overlap = 0;
    num_layers = LW'(nl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    while (!(done || err)) @(negedge clk);
  endtask

  task automatic full_run(int nl, string tag);
    go(nl);
    wait_end();
    chk(done == 1'b1 && err == 1'b0, "R10 run ends with done", 64'({done, err}), 64'(2));
    endcheck(nl - 1);
    chk(fetch_cnt == nl, "R2 one fetch per layer", 64'(fetch_cnt), 64'(nl));
    chk(int'(layer_idx) == nl, "R12 layer count", 64'(layer_idx), 64'(nl));
    $display("%s: overlapped load/store steps %0d", tag, overlap);
  endtask

  // watchdog
  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired R10 actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; num_layers = '0;
    // directed layers
    set_layer(0, 0, 8, 4, 8, 16, 3, 1, 1, 1, 2, 0);   // 8 tiles, two in-channel tiles per group
    set_layer(1, 1, 32, 12, 9, 7, 4, 3, 2, 0, 1, 3);  // fcn, row/col/stride/pad fields ignored
    set_layer(2, 0, 3, 2, 4, 8, 1, 1, 0, 0, 0, 0);    // single tile
    for (int i = 3; i < 7; i++) begin
      if ($urandom % 2 == 0)
        set_layer(i, 0, 1 + int'($urandom % 12), 1 + int'($urandom % 10), 1 + int'($urandom % 20),
                  1 + int'($urandom % 20), 1 + int'($urandom % 7), 1 + int'($urandom % 3),
                  int'($urandom % 4), int'($urandom % 2), int'($urandom % 8), 0);
      else begin
        int k;
        k = 1 << ($urandom % 3);
        set_layer(i, 1, k * (1 + int'($urandom % 12)), 1 + int'($urandom % 20), int'($urandom % 9),
                  int'($urandom % 9), k, int'($urandom % 9), int'($urandom % 9),
                  int'($urandom % 2), int'($urandom % 8), 1 + int'($urandom % 8));
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(done == 1'b0 && err == 1'b0, "R11 reset flags", 64'({done, err}), 64'(0));
    chk(!imem_rd && !ld_start && !cp_start && !st_start, "R11 reset commands",
        64'({imem_rd, ld_start, cp_start, st_start}), 64'(0));
    chk(layer_idx == '0, "R11 reset layer count", 64'(layer_idx), 64'(0));
    mon_en = 1;

    full_run(7, "random latency");
    lat_fix = 1;
    full_run(7, "unit latency");
    chk(overlap > 0, "R4 overlap provoked", 64'(overlap), 64'(1));
    lat_fix = 0;
    full_run(2, "short run");

    // bad type code in layer 1
    prog[1][1:0] = 2'd3;
    go(5);
    wait_end();
    chk(err == 1'b1 && done == 1'b0, "R1 unknown type stops", 64'({err, done}), 64'(2));
    chk(int'(layer_idx) == 1, "R1 stop layer", 64'(layer_idx), 64'(1));
    repeat (20) @(negedge clk);
    chk(err == 1'b1 && cnt_ld == 0 && cnt_cp == 0 && cnt_st == 0, "R1 no commands after error",
        64'(cnt_ld + cnt_cp + cnt_st), 64'(0));
    chk(fetch_cnt == 2, "R1 no fetch after error", 64'(fetch_cnt), 64'(2));

    // zero kernel factor on a fully connected layer
    prog[1] = enc(1);
    prog[0] = enc(1);
    prog[0][61:58] = 4'd0;
    go(3);
    wait_end();
    chk(err == 1'b1 && int'(layer_idx) == 0, "R1 zero kernel factor", 64'({err, layer_idx}), 64'(9'h100));

    // zero layer count
    go(0);
    repeat (5) @(negedge clk);
    chk(done == 1'b1 && err == 1'b0, "R10 zero layers done", 64'({done, err}), 64'(2));
    chk(fetch_cnt == 0, "R10 zero layers no fetch", 64'(fetch_cnt), 64'(0));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule